// File: doc/BRIEF.md
# NAND Page Program with Read-Back Verification

This block runs one page program on a raw NAND device and, when asked, proves the result by reading it back. A request carries a page address and a verify flag. The block sends the data-load command with a zero column and the page address. It streams the page bytes and then the spare bytes, both taken from an external page buffer with one cycle of read latency. It sends the program confirm, waits for the device's busy line to rise and fall, and reads the status byte. A set fail bit ends the request.

With verification on, the block reads the same page back from column zero. It compares every page-data byte against the buffer and then waits for a verdict from an external ECC checker. A correctable error on the first read-back makes the block reset the device and program the same page once more, without an erase. On that second pass a correctable error is only a warning. An uncorrectable error or any data mismatch ends the request with an I/O error.

All device traffic goes through one byte-wide handshake port. Each transfer carries a kind (command, address, write data or read data) and is held until the device side accepts it.

Top module: `nand_pv_top`

## Requirements
- R1: After reset, cyc_valid_o, done_o, err_o and warn_o are low, err_code_o is 0 and buf_addr_o is 0.
- R2: A request sends these transfers in order. First comes a command transfer (kind 0) with byte 0x80. Next come address transfers (kind 1): COL_BYTES zero bytes, then ROW_BYTES bytes of the page address, low byte first. Next come write-data transfers (kind 2) carrying buffer bytes 0 to PAGE_BYTES+SPARE_BYTES-1 in order. Last comes a command transfer with byte 0x10.
- R3: After the confirm, the block waits for dev_busy_i to go high and then low. It then sends command 0x70 and one read transfer (kind 3, byte 0). If bit 0 of the returned byte is set, the request ends with error code 1.
- R4: With verification off and a clear status bit, the request ends with done_o and no error, and no further transfers follow.
- R5: With verification on, a passing status is followed by command 0x00, the same address bytes as in R2, and command 0x30. The block then waits for busy to go high and then low, reads PAGE_BYTES+SPARE_BYTES bytes, and waits for ecc_valid_i.
- R6: A correctable indication on the first read-back sends command 0xFF and waits for busy to go high and then low. It then repeats the whole sequence of R2, R3 and R5 on the same page. At most one such rewrite happens per request.
- R7: An uncorrectable indication ends the request with error code 2. It loses only to the first-pass rewrite of R6.
- R8: Any page-data byte read back that differs from the buffer ends the request with error code 3, unless R7 applies. Spare bytes are not compared.
- R9: A correctable indication on the second read-back, with no mismatch, ends the request with done_o and warn_o high and no error.
- R10: done_o is a one-cycle pulse at the end of every request. err_o and warn_o pulse only together with done_o. err_code_o is 0 on success.
- R11: While cyc_valid_o is high and cyc_ready_i is low, cyc_valid_o, cyc_kind_o and cyc_byte_o hold their values.
- R12: The rewrite allowance is restored for each new request, so consecutive requests may each rewrite once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, taken when idle |
| page_i | input | PA_W | Target page address |
| verify_i | input | 1 | Enable read-back verification |
| cyc_valid_o | output | 1 | Device transfer pending |
| cyc_kind_o | output | 2 | 0 command, 1 address, 2 write data, 3 read data |
| cyc_byte_o | output | 8 | Command, address or write byte |
| cyc_ready_i | input | 1 | Device accepts the pending transfer |
| rd_byte_i | input | 8 | Read byte, valid with cyc_ready_i on a read |
| dev_busy_i | input | 1 | Device busy line, high while busy |
| buf_addr_o | output | BA_W | Page buffer byte address |
| buf_data_i | input | 8 | Page buffer byte, one cycle after address |
| ecc_valid_i | input | 1 | ECC verdict strobe for the last read-back |
| ecc_corr_i | input | 1 | Correctable error found |
| ecc_uncorr_i | input | 1 | Uncorrectable error found |
| done_o | output | 1 | Request finished pulse |
| err_o | output | 1 | Request failed pulse |
| err_code_o | output | 2 | 1 program fail, 2 uncorrectable, 3 mismatch |
| warn_o | output | 1 | Correctable error tolerated on the rewrite pass |

## Verification
The hardest path to reach is the rewrite. The device model has to flag a correctable error on the first read-back only. Then the whole program, status and read-back sequence must appear a second time before a verdict on the second pass decides the outcome. The bench gives its ECC model one verdict per pass and sweeps every pair of first-pass and second-pass verdicts. It crosses these with status failure, verify mode, and a corrupted page byte or spare byte. The handshake stalls and busy lengths vary from run to run. Runs follow one another without reset, so a rewrite request directly after another one exercises the restored allowance.

// File: rtl/nand_pv_pkg.sv
package nand_pv_pkg;
  typedef enum logic [1:0] {
    CYC_CMD = 2'd0, CYC_ADDR = 2'd1, CYC_WDATA = 2'd2, CYC_RDATA = 2'd3
  } cyc_kind_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0, ERR_PROG = 2'd1, ERR_UNCORR = 2'd2, ERR_MISMATCH = 2'd3
  } err_code_e;

  localparam logic [7:0] OP_LOAD     = 8'h80;
  localparam logic [7:0] OP_CONFIRM  = 8'h10;
  localparam logic [7:0] OP_STATUS   = 8'h70;
  localparam logic [7:0] OP_RD_SETUP = 8'h00;
  localparam logic [7:0] OP_RD_GO    = 8'h30;
  localparam logic [7:0] OP_RESET    = 8'hFF;

  typedef enum logic [3:0] {
    PH_IDLE, PH_LOAD_CMD, PH_LOAD_ADDR, PH_LOAD_DATA, PH_CONF_CMD, PH_CONF_WAIT,
    PH_STAT_CMD, PH_STAT_RD, PH_RD_CMD, PH_RD_ADDR, PH_RD_GO, PH_RD_WAIT,
    PH_RD_DATA, PH_ECC_WAIT, PH_RST_CMD, PH_RST_WAIT
  } phase_e;

  typedef enum logic [1:0] {SB_GO, SB_LOAD, SB_BUS, SB_WAIT} sub_e;
endpackage

// File: rtl/nand_pv_busywait.sv
module nand_pv_busywait (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic busy_i,
  output logic done_o
);
  typedef enum logic [1:0] {BW_IDLE, BW_HI, BW_LO} bw_e;
  bw_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= BW_IDLE;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        BW_IDLE: if (arm_i) st_q <= BW_HI;
        BW_HI:   if (busy_i) st_q <= BW_LO;
        BW_LO:   if (!busy_i) begin
                   st_q   <= BW_IDLE;
                   done_o <= 1'b1;
                 end
        default: st_q <= BW_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_pv_cmp.sv
module nand_pv_cmp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         miss_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) miss_o <= 1'b0;
    else if (en_i && (a_i != b_i)) miss_o <= 1'b1;
  end
endmodule

// File: rtl/nand_pv_top.sv
module nand_pv_top
  import nand_pv_pkg::*;
#(
  parameter int PA_W        = 16,
  parameter int COL_BYTES   = 2,
  parameter int ROW_BYTES   = 2,
  parameter int PAGE_BYTES  = 8,
  parameter int SPARE_BYTES = 2,
  localparam int TOTAL      = PAGE_BYTES + SPARE_BYTES,
  localparam int BA_W       = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [PA_W-1:0] page_i,
  input  logic            verify_i,
  output logic            cyc_valid_o,
  output logic [1:0]      cyc_kind_o,
  output logic [7:0]      cyc_byte_o,
  input  logic            cyc_ready_i,
  input  logic [7:0]      rd_byte_i,
  input  logic            dev_busy_i,
  output logic [BA_W-1:0] buf_addr_o,
  input  logic [7:0]      buf_data_i,
  input  logic            ecc_valid_i,
  input  logic            ecc_corr_i,
  input  logic            ecc_uncorr_i,
  output logic            done_o,
  output logic            err_o,
  output logic [1:0]      err_code_o,
  output logic            warn_o
);
  localparam int ADDR_BYTES = COL_BYTES + ROW_BYTES;
  localparam int CNT_MAX    = (TOTAL > ADDR_BYTES) ? TOTAL : ADDR_BYTES;
  localparam int IDX_W      = $clog2(CNT_MAX + 1);
  localparam int AV_W       = 8 * ADDR_BYTES;

  phase_e            ph_q;
  sub_e              sub_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PA_W-1:0]   page_q;
  logic              verify_q, pass_q;
  logic              valid_q, done_q, err_q, warn_q;
  logic [1:0]        kind_q, code_q;
  logic [7:0]        byte_q;

  logic              g_issue, g_load, arm, bw_done, miss, cmp_en, cmp_clr;
  logic [1:0]        g_kind;
  logic [7:0]        g_byte;
  logic [AV_W-1:0]   avec, ash;

  // address bytes: zero column first, then page address low byte first
  always_comb begin
    avec = '0;
    avec[8*COL_BYTES +: PA_W] = page_q;
    ash = avec >> {idx_q, 3'b000};
  end

  always_comb begin
    g_issue = 1'b1;
    g_load  = 1'b0;
    g_kind  = CYC_CMD;
    g_byte  = 8'h00;
    case (ph_q)
      PH_LOAD_CMD: g_byte = OP_LOAD;
      PH_CONF_CMD: g_byte = OP_CONFIRM;
      PH_STAT_CMD: g_byte = OP_STATUS;
      PH_RD_CMD:   g_byte = OP_RD_SETUP;
      PH_RD_GO:    g_byte = OP_RD_GO;
      PH_RST_CMD:  g_byte = OP_RESET;
      PH_STAT_RD:  g_kind = CYC_RDATA;
      PH_LOAD_ADDR, PH_RD_ADDR: begin
        g_kind = CYC_ADDR;
        g_byte = ash[7:0];
      end
      PH_LOAD_DATA, PH_RD_DATA: begin
        g_issue = 1'b0;
        g_load  = 1'b1;
      end
      default: g_issue = 1'b0;
    endcase
  end

  assign arm     = (sub_q == SB_GO) &&
                   (ph_q == PH_CONF_WAIT || ph_q == PH_RD_WAIT || ph_q == PH_RST_WAIT);
  assign cmp_en  = (sub_q == SB_BUS) && cyc_ready_i && (ph_q == PH_RD_DATA) &&
                   (idx_q < IDX_W'(PAGE_BYTES));
  assign cmp_clr = (sub_q == SB_GO) && (ph_q == PH_RD_CMD);

  nand_pv_busywait u_bw (
    .clk(clk), .rst(rst), .arm_i(arm), .busy_i(dev_busy_i), .done_o(bw_done)
  );

  nand_pv_cmp #(.W(8)) u_cmp (
    .clk(clk), .rst(rst), .clr_i(cmp_clr), .en_i(cmp_en),
    .a_i(rd_byte_i), .b_i(buf_data_i), .miss_o(miss)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= PH_IDLE;   sub_q <= SB_GO;    idx_q <= '0;
      page_q <= '0;      verify_q <= 1'b0;  pass_q <= 1'b0;
      valid_q <= 1'b0;   kind_q <= CYC_CMD; byte_q <= 8'h00;
      done_q <= 1'b0;    err_q <= 1'b0;     warn_q <= 1'b0;
      code_q <= ERR_NONE;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      warn_q <= 1'b0;
      case (sub_q)
        SB_GO: begin
          if (ph_q == PH_IDLE) begin
            if (start_i) begin
              page_q   <= page_i;
              verify_q <= verify_i;
              pass_q   <= 1'b0;
              idx_q    <= '0;
              ph_q     <= PH_LOAD_CMD;
            end
          end else if (g_issue) begin
            valid_q <= 1'b1;
            kind_q  <= g_kind;
            byte_q  <= g_byte;
            sub_q   <= SB_BUS;
          end else if (g_load) begin
            sub_q <= SB_LOAD;
          end else begin
            sub_q <= SB_WAIT;
          end
        end
        SB_LOAD: begin
          valid_q <= 1'b1;
          kind_q  <= (ph_q == PH_LOAD_DATA) ? CYC_WDATA : CYC_RDATA;
          byte_q  <= (ph_q == PH_LOAD_DATA) ? buf_data_i : 8'h00;
          sub_q   <= SB_BUS;
        end
        SB_BUS: if (cyc_ready_i) begin
          valid_q <= 1'b0;
          sub_q   <= SB_GO;
          case (ph_q)
            PH_LOAD_CMD: begin ph_q <= PH_LOAD_ADDR; idx_q <= '0; end
            PH_RD_CMD:   begin ph_q <= PH_RD_ADDR;   idx_q <= '0; end
            PH_LOAD_ADDR, PH_RD_ADDR: begin
              if (idx_q == IDX_W'(ADDR_BYTES - 1)) begin
                idx_q <= '0;
                ph_q  <= (ph_q == PH_LOAD_ADDR) ? PH_LOAD_DATA : PH_RD_GO;
              end else idx_q <= idx_q + 1'b1;
            end
            PH_LOAD_DATA, PH_RD_DATA: begin
              if (idx_q == IDX_W'(TOTAL - 1)) begin
                idx_q <= '0;
                ph_q  <= (ph_q == PH_LOAD_DATA) ? PH_CONF_CMD : PH_ECC_WAIT;
              end else idx_q <= idx_q + 1'b1;
            end
            PH_CONF_CMD: ph_q <= PH_CONF_WAIT;
            PH_STAT_CMD: ph_q <= PH_STAT_RD;
            PH_RD_GO:    ph_q <= PH_RD_WAIT;
            PH_RST_CMD:  ph_q <= PH_RST_WAIT;
            PH_STAT_RD: begin
              if (rd_byte_i[0] || !verify_q) begin
                ph_q   <= PH_IDLE;
                done_q <= 1'b1;
                err_q  <= rd_byte_i[0];
                code_q <= rd_byte_i[0] ? ERR_PROG : ERR_NONE;
              end else ph_q <= PH_RD_CMD;
            end
            default: ph_q <= PH_IDLE;
          endcase
        end
        SB_WAIT: begin
          case (ph_q)
            PH_CONF_WAIT: if (bw_done) begin ph_q <= PH_STAT_CMD; sub_q <= SB_GO; end
            PH_RD_WAIT:   if (bw_done) begin ph_q <= PH_RD_DATA; idx_q <= '0; sub_q <= SB_GO; end
            PH_RST_WAIT:  if (bw_done) begin
                            ph_q <= PH_LOAD_CMD; pass_q <= 1'b1; idx_q <= '0; sub_q <= SB_GO;
                          end
            PH_ECC_WAIT:  if (ecc_valid_i) begin
                            sub_q <= SB_GO;
                            if (!pass_q && ecc_corr_i) begin
                              ph_q <= PH_RST_CMD;
                            end else begin
                              ph_q   <= PH_IDLE;
                              done_q <= 1'b1;
                              if (ecc_uncorr_i) begin
                                err_q <= 1'b1; code_q <= ERR_UNCORR;
                              end else if (miss) begin
                                err_q <= 1'b1; code_q <= ERR_MISMATCH;
                              end else begin
                                code_q <= ERR_NONE; warn_q <= ecc_corr_i;
                              end
                            end
                          end
            default: begin ph_q <= PH_IDLE; sub_q <= SB_GO; end
          endcase
        end
        default: sub_q <= SB_GO;
      endcase
    end
  end

  assign cyc_valid_o = valid_q;
  assign cyc_kind_o  = kind_q;
  assign cyc_byte_o  = byte_q;
  assign buf_addr_o  = idx_q[BA_W-1:0];
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign err_code_o  = code_q;
  assign warn_o      = warn_q;
endmodule

// File: rtl/nand_pv_chk.sv
module nand_pv_chk (
  input logic       clk,
  input logic       rst,
  input logic       cyc_valid_o,
  input logic [1:0] cyc_kind_o,
  input logic [7:0] cyc_byte_o,
  input logic       cyc_ready_i,
  input logic       done_o,
  input logic       err_o,
  input logic [1:0] err_code_o,
  input logic       warn_o
);
  logic [1:0] rst_cnt;

  always_ff @(posedge clk) begin
    if (rst || done_o) rst_cnt <= 2'd0;
    else if (cyc_valid_o && cyc_ready_i && cyc_kind_o == 2'd0 &&
             cyc_byte_o == 8'hFF && rst_cnt != 2'd3)
      rst_cnt <= rst_cnt + 2'd1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R10
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (done_o && err_code_o != 2'd0)); // R10
  AST_OK_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done_o && !err_o) |-> (err_code_o == 2'd0)); // R10
  AST_WARN_ONLY_OK: assert property (@(posedge clk) disable iff (rst)
    warn_o |-> (done_o && !err_o)); // R9
  AST_CYC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid_o && !cyc_ready_i) |=>
      (cyc_valid_o && $stable(cyc_kind_o) && $stable(cyc_byte_o))); // R11
  AST_ONE_REWRITE: assert property (@(posedge clk) disable iff (rst)
    rst_cnt <= 2'd1); // R6
endmodule

bind nand_pv_top nand_pv_chk chk_i (.*);

// File: tb/nand_pv_top_tb_top.sv
module nand_pv_top_tb_top;
  localparam int PA_W = 16, COLB = 2, ROWB = 2, PAGE = 8, SPARE = 2;
  localparam int TOTAL = PAGE + SPARE;
  localparam int BA_W = $clog2(TOTAL);

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic            start_i = 1'b0, verify_i = 1'b0;
  logic [PA_W-1:0] page_i = '0;
  logic            cyc_valid_o, cyc_ready_i, dev_busy_i;
  logic [1:0]      cyc_kind_o, err_code_o;
  logic [7:0]      cyc_byte_o, rd_byte_i, buf_data_i;
  logic [BA_W-1:0] buf_addr_o;
  logic            ecc_valid_i, ecc_corr_i, ecc_uncorr_i;
  logic            done_o, err_o, warn_o;

  nand_pv_top #(.PA_W(PA_W), .COL_BYTES(COLB), .ROW_BYTES(ROWB),
                .PAGE_BYTES(PAGE), .SPARE_BYTES(SPARE)) dut_i (.*);

  // page buffer with one cycle read latency
  logic [7:0] mem [TOTAL];
  always @(posedge clk) buf_data_i <= mem[buf_addr_o];

  // scenario knobs, written only by the stimulus process
  logic       clr_req = 1'b0;
  int         cfg_pf = 0, cfg_mm = 0, cfg_stall = 0, cfg_mmidx = 0;
  int         cfg_e0 = 0, cfg_e1 = 0;

  // device model state, written only by the model
  logic [9:0] log_q [256];
  int   log_n, rd_cnt, rd_pass, busy_cnt, ecc_cnt, stall_cnt, hold_fail, done_cnt;
  logic [7:0] last_cmd;
  logic [9:0] first_kb;
  logic       seen_valid, cap_err, cap_warn;
  logic [1:0] cap_code;

  initial begin
    cyc_ready_i = 0; dev_busy_i = 0; rd_byte_i = 0;
    ecc_valid_i = 0; ecc_corr_i = 0; ecc_uncorr_i = 0;
    log_n = 0; rd_cnt = 0; rd_pass = 0; busy_cnt = 0; ecc_cnt = 0; stall_cnt = 0;
    hold_fail = 0; done_cnt = 0; last_cmd = 0; first_kb = 0; seen_valid = 0;
    cap_err = 0; cap_warn = 0; cap_code = 0;
  end

  always @(negedge clk) begin
    if (clr_req) begin
      log_n = 0; rd_pass = 0; done_cnt = 0; rd_cnt = 0;
    end
    if (done_o) begin
      done_cnt = done_cnt + 1;
      cap_err = err_o; cap_code = err_code_o; cap_warn = warn_o;
    end
    if (busy_cnt > 0) begin
      busy_cnt = busy_cnt - 1;
      if (busy_cnt == 0) dev_busy_i = 0;
    end
    ecc_valid_i = 0;
    if (ecc_cnt > 0) begin
      ecc_cnt = ecc_cnt - 1;
      if (ecc_cnt == 0) begin
        ecc_valid_i  = 1;
        ecc_corr_i   = ((rd_pass == 0) ? cfg_e0 : cfg_e1) == 1;
        ecc_uncorr_i = ((rd_pass == 0) ? cfg_e0 : cfg_e1) == 2;
        rd_pass = rd_pass + 1;
      end
    end
    if (cyc_ready_i) begin
      cyc_ready_i = 0;
      seen_valid = 0;
    end else if (cyc_valid_o) begin
      if (!seen_valid) begin
        seen_valid = 1;
        first_kb = {cyc_kind_o, cyc_byte_o};
      end
      if (stall_cnt < cfg_stall) stall_cnt = stall_cnt + 1;
      else begin
        stall_cnt = 0;
        cyc_ready_i = 1;
        if (first_kb != {cyc_kind_o, cyc_byte_o}) hold_fail = hold_fail + 1;
        if (log_n < 256) log_q[log_n] = {cyc_kind_o, cyc_byte_o};
        log_n = log_n + 1;
        if (cyc_kind_o == 2'd0) begin
          last_cmd = cyc_byte_o;
          if (cyc_byte_o == 8'h10 || cyc_byte_o == 8'h30 || cyc_byte_o == 8'hFF) begin
            dev_busy_i = 1;
            busy_cnt = 4 + cfg_stall;
          end
          if (cyc_byte_o == 8'h00) rd_cnt = 0;
        end else if (cyc_kind_o == 2'd3) begin
          if (last_cmd == 8'h70) rd_byte_i = 8'h40 | 8'(cfg_pf);
          else begin
            rd_byte_i = mem[rd_cnt];
            if ((cfg_mm == 1 && rd_cnt == cfg_mmidx) || (cfg_mm == 2 && rd_cnt == TOTAL - 1))
              rd_byte_i = rd_byte_i ^ 8'h5A;
            rd_cnt = rd_cnt + 1;
            if (rd_cnt == TOTAL) ecc_cnt = 2 + cfg_stall;
          end
        end
      end
    end
  end

  int errors = 0, checks = 0;
  logic [9:0] exp_q [256];
  int exp_n;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [7:0] b);
    if (exp_n < 256) exp_q[exp_n] = {k, b};
    exp_n = exp_n + 1;
  endtask

  task automatic push_addr(input logic [PA_W-1:0] pg);
    for (int i = 0; i < COLB; i++) push(2'd1, 8'h00);
    for (int i = 0; i < ROWB; i++) push(2'd1, 8'(pg >> (8 * i)));
  endtask

  task automatic push_prog(input logic [PA_W-1:0] pg);
    push(2'd0, 8'h80);
    push_addr(pg);
    for (int i = 0; i < TOTAL; i++) push(2'd2, mem[i]);
    push(2'd0, 8'h10);
    push(2'd0, 8'h70);
    push(2'd3, 8'h00);
  endtask

  task automatic push_read(input logic [PA_W-1:0] pg);
    push(2'd0, 8'h00);
    push_addr(pg);
    push(2'd0, 8'h30);
    for (int i = 0; i < TOTAL; i++) push(2'd3, 8'h00);
  endtask

  initial begin
    bit prev_retry;
    int run;
    prev_retry = 0;
    run = 0;
    repeat (3) @(negedge clk);
    check(cyc_valid_o == 0 && done_o == 0 && err_o == 0 && warn_o == 0,
          "R1", "reset outputs", {cyc_valid_o, done_o, err_o, warn_o}, 0);
    check(err_code_o == 0 && buf_addr_o == 0, "R1", "reset code/addr",
          {err_code_o, 4'(buf_addr_o)}, 0);
    rst = 0;
    @(negedge clk);

    for (int pf = 0; pf < 2; pf++)
    for (int ver = 0; ver < 2; ver++)
    for (int e0 = 0; e0 < 3; e0++)
    for (int e1 = 0; e1 < 3; e1++)
    for (int mm = 0; mm < 3; mm++) begin
      logic [PA_W-1:0] pg;
      int waited, x_code;
      bit x_err, x_warn, retry, seq_ok;
      string tag;
      int bad_i;
      pg = PA_W'(16'h1234 + run * 16'h0137);
      cfg_pf = pf; cfg_e0 = e0; cfg_e1 = e1; cfg_mm = mm;
      cfg_stall = run % 3; cfg_mmidx = (run + e0) % PAGE;
      for (int i = 0; i < TOTAL; i++) mem[i] = 8'((i * 37 + run * 11 + 5) & 8'hFF);
      clr_req = 1;
      @(negedge clk);
      clr_req = 0;

      exp_n = 0;
      retry = !pf && ver && e0 == 1;
      push_prog(pg);
      if (!pf && ver) begin
        push_read(pg);
        if (retry) begin
          push(2'd0, 8'hFF);
          push_prog(pg);
          push_read(pg);
        end
      end
      x_err = 0; x_code = 0; x_warn = 0;
      if (pf) begin x_err = 1; x_code = 1; end
      else if (ver) begin
        int ev;
        ev = retry ? e1 : e0;
        if (ev == 2) begin x_err = 1; x_code = 2; end
        else if (mm == 1) begin x_err = 1; x_code = 3; end
        else x_warn = retry && e1 == 1;
      end
      if (pf) tag = "R3";
      else if (!ver) tag = "R4";
      else if (retry) tag = prev_retry ? "R12" : "R6";
      else if (e0 == 2) tag = "R7";
      else if (mm == 1) tag = "R8";
      else tag = "R5";

      start_i = 1; page_i = pg; verify_i = ver[0];
      @(negedge clk);
      start_i = 0;
      waited = 0;
      while (done_cnt == 0 && waited < 5000) begin
        @(negedge clk);
        waited = waited + 1;
      end
      check(waited < 5000, tag, "watchdog", waited, 5000);
      repeat (4) @(negedge clk);

      check(log_n == exp_n, {"R2 ", tag}, "transfer count", log_n, exp_n);
      seq_ok = 1; bad_i = 0;
      for (int i = 0; i < exp_n && i < log_n && i < 256; i++)
        if (seq_ok && log_q[i] != exp_q[i]) begin seq_ok = 0; bad_i = i; end
      check(seq_ok, {"R2 ", tag}, $sformatf("transfer %0d", bad_i),
            log_q[bad_i], exp_q[bad_i]);
      check(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
      if (x_code == 1) tag = "R3";
      else if (x_code == 2) tag = "R7";
      else if (x_code == 3) tag = "R8";
      else if (x_warn) tag = "R9";
      check(cap_err == x_err && cap_code == 2'(x_code) && cap_warn == x_warn,
            tag, "outcome err/code/warn", {cap_err, cap_code, cap_warn},
            {x_err, 2'(x_code), x_warn});
      prev_retry = retry;
      run = run + 1;
    end
    check(hold_fail == 0, "R11", "held transfer changed", hold_fail, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule